// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block is the device-side command engine of a serial NOR flash. A byte-level serial shift stage in front of it delivers each received byte with a one-cycle strobe while the active-low select is held. The engine returns the byte to be shifted out in the next byte slot. The first byte of every select frame is an opcode. The engine then collects address bytes and does one of four things: streams read data, accepts page-program data, erases a sector or the whole array, or returns a fixed three-byte identification code. The storage is a small parameterized byte array inside the block.

Write permission is decided outside the block. A status unit supplies the write-enable latch as an input. A protection unit watches the target address output, plus a flag that asks about the whole array, and answers with a single grant input. A command that fails either test leaves the array untouched. The engine can switch from three-byte to four-byte addressing, and the wider mode stays in force until reset.

Top module: `spi_nor_cmd_engine`

## Requirements
- R1: Only the first byte of a frame is decoded as an opcode: 0x03 read, 0x02 program, 0xD8 sector erase, 0xC7 bulk erase, 0x9F identify, 0xB7 four-byte mode. After any other opcode the engine ignores the rest of the frame and `tx_byte` stays 0xFF.
- R2: After the identify opcode, `tx_byte` gives 0x20, then 0xBA, then 0x19 on the three following byte slots, and 0xFF after that.
- R3: Address bytes arrive most significant first. Three address bytes are taken while four-byte mode is off.
- R4: Opcode 0xB7 turns on four-byte mode. In that mode four address bytes are taken, and the mode persists across frames until reset.
- R5: A read presents the byte at the given address in the slot after the last address byte. Each further byte strobe presents the next higher address, with no limit, for as long as select is held.
- R6: Each program data byte is ANDed into the stored byte, so a program can only clear bits. The address then advances within its 256-byte page and wraps from the last byte of the page to the first.
- R7: Program and erase change the array only when `wel` is 1 and `prot_grant` is 1. `prot_addr` carries the target address during address collection and programming. `prot_bulk` is 1 while an opcode is awaited, so that the grant can cover a bulk erase.
- R8: A granted sector erase sets every byte of the sector that holds the address to 0xFF. It happens on the last address byte, and other sectors are unchanged.
- R9: A granted bulk erase sets every byte of the array to 0xFF.
- R10: Raising `cs_n` abandons any partly received command. The next byte after select falls again is decoded as an opcode.
- R11: Reset sets every array byte to 0xFF, sets `tx_byte` to 0xFF and turns off four-byte mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low frame select |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Byte to shift out in the next slot |
| wel | input | 1 | Write-enable latch from the status unit |
| prot_addr | output | 32 | Address being checked by the protection unit |
| prot_bulk | output | 1 | Asks whether the whole array may be erased |
| prot_grant | input | 1 | Protection unit allows the pending change |

## Verification
Every response is registered. `tx_byte` changes at the same clock edge that accepts the byte strobe, so each result is due one cycle after the stimulus. A program or erase is applied to the array at that same edge and shows up in the next read frame. The driver queues one expected entry for each byte it sends. The monitor waits for the edge that accepts the strobe and compares 5 ns later, so it never samples on an edge. Ignored commands (no latch, no grant, unknown opcode) are checked by reading the affected bytes back through a later read frame.

// File: rtl/spi_nor_cmd_engine.sv
module spi_nor_cmd_engine #(
  parameter int MEM_BYTES    = 2048,
  parameter int SECTOR_BYTES = 512,
  parameter int PAGE_BYTES   = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic [7:0]  tx_byte,
  input  logic        wel,
  output logic [31:0] prot_addr,
  output logic        prot_bulk,
  input  logic        prot_grant
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int SW = $clog2(SECTOR_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  typedef enum logic [2:0] {S_OP, S_ADDR, S_READ, S_PROG, S_ID, S_DONE} st_t;
  typedef enum logic [1:0] {C_READ, C_PROG, C_ERASE} cmd_t;

  logic [7:0]  mem [MEM_BYTES];
  st_t         st;
  cmd_t        cmd;
  logic [31:0] addr;
  logic [1:0]  cnt;
  logic        four_b;

  wire         fire    = rx_valid & ~cs_n;
  wire  [31:0] naddr   = {addr[23:0], rx_byte};
  wire         last_ab = (cnt == (four_b ? 2'd3 : 2'd2));
  wire         permit  = wel & prot_grant;
  wire         bulk_go = fire && st == S_OP && rx_byte == 8'hC7 && permit;
  wire         sect_go = fire && st == S_ADDR && last_ab && cmd == C_ERASE && permit;
  wire         prog_go = fire && st == S_PROG && permit;

  assign prot_addr = (st == S_ADDR) ? naddr : addr;
  assign prot_bulk = (st == S_OP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_OP;
      cmd     <= C_READ;
      addr    <= '0;
      cnt     <= '0;
      four_b  <= 1'b0;
      tx_byte <= 8'hFF;
    end else if (cs_n) begin
      st      <= S_OP;
      cnt     <= '0;
      tx_byte <= 8'hFF;
    end else if (rx_valid) begin
      tx_byte <= 8'hFF;
      case (st)
        S_OP: begin
          addr <= '0;
          cnt  <= '0;
          case (rx_byte)
            8'h9F: begin st <= S_ID; tx_byte <= 8'h20; cnt <= 2'd1; end
            8'h03: begin st <= S_ADDR; cmd <= C_READ; end
            8'h02: begin st <= S_ADDR; cmd <= C_PROG; end
            8'hD8: begin st <= S_ADDR; cmd <= C_ERASE; end
            8'hB7: begin st <= S_DONE; four_b <= 1'b1; end
            default: st <= S_DONE;
          endcase
        end
        S_ADDR: begin
          addr <= naddr;
          cnt  <= cnt + 2'd1;
          if (last_ab) begin
            case (cmd)
              C_READ: begin
                tx_byte <= mem[naddr[AW-1:0]];
                addr    <= naddr + 32'd1;
                st      <= S_READ;
              end
              C_PROG:  st <= S_PROG;
              default: st <= S_DONE;
            endcase
          end
        end
        S_READ: begin
          tx_byte <= mem[addr[AW-1:0]];
          addr    <= addr + 32'd1;
        end
        S_PROG: addr <= {addr[31:PW], addr[PW-1:0] + PW'(1)};
        S_ID: begin
          case (cnt)
            2'd1:    tx_byte <= 8'hBA;
            2'd2:    tx_byte <= 8'h19;
            default: tx_byte <= 8'hFF;
          endcase
          if (cnt != 2'd3) cnt <= cnt + 2'd1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < MEM_BYTES; i++) begin
        if (bulk_go || (sect_go && ((AW'(i) >> SW) == (naddr[AW-1:0] >> SW))))
          mem[i] <= 8'hFF;
        else if (prog_go && AW'(i) == addr[AW-1:0])
          mem[i] <= mem[i] & rx_byte;
      end
    end
  end

  assert_id_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && st == S_OP && rx_byte == 8'h9F) |=> (tx_byte == 8'h20));

  assert_four_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    four_b |=> four_b);

  assert_read_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && st == S_READ) |=> (addr == $past(addr) + 32'd1));

  assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && st == S_PROG) |=> (addr[31:PW] == $past(addr[31:PW])));

  assert_bulk_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_go |=> (mem[0] == 8'hFF && mem[MEM_BYTES-1] == 8'hFF));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (st == S_OP));
endmodule

// File: tb/tb_spi_nor_cmd_engine.sv
module tb_spi_nor_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic [7:0]  tx_byte;
  logic        wel = 1'b0;
  logic [31:0] prot_addr;
  logic        prot_bulk;
  logic        prot_grant;
  logic [31:0] plo = 32'hFFFF_FFFF;
  logic [31:0] phi = 32'h0;
  logic        bulk_ok = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  bit         chk_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  assign prot_grant = prot_bulk ? bulk_ok : !(prot_addr >= plo && prot_addr <= phi);

  spi_nor_cmd_engine dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_byte(tx_byte), .wel(wel), .prot_addr(prot_addr), .prot_bulk(prot_bulk),
    .prot_grant(prot_grant)
  );

  initial begin
    forever begin
      @(posedge clk);
      if (rx_valid && !cs_n && exp_q.size() > 0) begin
        logic [7:0] e;
        bit c;
        string t;
        #5;
        e = exp_q.pop_front();
        c = chk_q.pop_front();
        t = tag_q.pop_front();
        if (c) begin
          n_cmp++;
          if (tx_byte !== e) begin
            n_bad++;
            $display("FAIL %s: tx_byte actual %h expected %h", t, tx_byte, e);
          end
        end
      end
    end
  end

  task automatic xb(input logic [7:0] b, input bit c, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    chk_q.push_back(c);
    tag_q.push_back(t);
    rx_byte  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic fbeg();
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic fend();
    @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic prog3(input logic [23:0] a, input logic [7:0] d);
    fbeg(); xb(8'h02, 0, 0, ""); xb(a[23:16], 0, 0, ""); xb(a[15:8], 0, 0, "");
    xb(a[7:0], 0, 0, ""); xb(d, 0, 0, ""); fend();
  endtask

  task automatic read1(input logic [23:0] a, input logic [7:0] e, input string t);
    fbeg(); xb(8'h03, 0, 0, ""); xb(a[23:16], 0, 0, ""); xb(a[15:8], 0, 0, "");
    xb(a[7:0], 1, e, t); fend();
  endtask

  task automatic erase3(input logic [23:0] a);
    fbeg(); xb(8'hD8, 0, 0, ""); xb(a[23:16], 0, 0, ""); xb(a[15:8], 0, 0, "");
    xb(a[7:0], 0, 0, ""); fend();
  endtask

  task automatic one(input logic [7:0] op);
    fbeg(); xb(op, 0, 0, ""); fend();
  endtask

  initial begin
    do_reset();
    n_cmp++;
    if (tx_byte !== 8'hFF) begin
      n_bad++;
      $display("FAIL R11 reset: tx_byte actual %h expected ff", tx_byte);
    end

    // R2 identification
    fbeg(); xb(8'h9F, 1, 8'h20, "R2 id0"); xb(8'h00, 1, 8'hBA, "R2 id1");
    xb(8'h00, 1, 8'h19, "R2 id2"); xb(8'h00, 1, 8'hFF, "R2 id3"); fend();

    // R11 erased array after reset, R5 streaming
    fbeg(); xb(8'h03, 0, 0, ""); xb(8'h00, 0, 0, ""); xb(8'h01, 0, 0, "");
    xb(8'h00, 1, 8'hFF, "R11 erased"); xb(8'h00, 1, 8'hFF, "R5 erased next"); fend();

    // R3/R6 program, then R5 stream back
    wel = 1'b1;
    fbeg(); xb(8'h02, 0, 0, ""); xb(8'h00, 0, 0, ""); xb(8'h01, 0, 0, ""); xb(8'hF0, 0, 0, "");
    xb(8'hA5, 0, 0, ""); xb(8'h3C, 0, 0, ""); xb(8'h0F, 0, 0, ""); fend();
    fbeg(); xb(8'h03, 0, 0, ""); xb(8'h00, 0, 0, ""); xb(8'h01, 0, 0, "");
    xb(8'hF0, 1, 8'hA5, "R3 msb first"); xb(8'h00, 1, 8'h3C, "R5 stream1");
    xb(8'h00, 1, 8'h0F, "R5 stream2"); xb(8'h00, 1, 8'hFF, "R5 stream3"); fend();

    // R6 AND into stored value
    fbeg(); xb(8'h02, 0, 0, ""); xb(8'h00, 0, 0, ""); xb(8'h01, 0, 0, ""); xb(8'hF0, 0, 0, "");
    xb(8'h0F, 0, 0, ""); xb(8'hF0, 0, 0, ""); fend();
    fbeg(); xb(8'h03, 0, 0, ""); xb(8'h00, 0, 0, ""); xb(8'h01, 0, 0, "");
    xb(8'hF0, 1, 8'h05, "R6 and0"); xb(8'h00, 1, 8'h30, "R6 and1"); fend();

    // R6 page wrap; R5 read crosses page
    fbeg(); xb(8'h02, 0, 0, ""); xb(8'h00, 0, 0, ""); xb(8'h00, 0, 0, ""); xb(8'hFE, 0, 0, "");
    xb(8'h11, 0, 0, ""); xb(8'h22, 0, 0, ""); xb(8'h33, 0, 0, ""); fend();
    fbeg(); xb(8'h03, 0, 0, ""); xb(8'h00, 0, 0, ""); xb(8'h00, 0, 0, "");
    xb(8'hFE, 1, 8'h11, "R6 wrap a"); xb(8'h00, 1, 8'h22, "R6 wrap b");
    xb(8'h00, 1, 8'hFF, "R5 cross page"); fend();
    read1(24'h000000, 8'h33, "R6 wrap to page start");

    // R7 latch clear blocks program
    wel = 1'b0;
    prog3(24'h000300, 8'h00);
    read1(24'h000300, 8'hFF, "R7 no latch");
    // R7 grant denied
    wel = 1'b1; plo = 32'h340; phi = 32'h37F;
    prog3(24'h000340, 8'h00);
    read1(24'h000340, 8'hFF, "R7 denied");
    prog3(24'h000380, 8'h00);
    read1(24'h000380, 8'h00, "R7 granted");
    plo = 32'hFFFF_FFFF; phi = 32'h0;

    // R8 sector erase
    prog3(24'h000210, 8'h42);
    erase3(24'h000105);
    read1(24'h0001F0, 8'hFF, "R8 sector hit");
    read1(24'h000000, 8'hFF, "R8 sector start");
    read1(24'h000210, 8'h42, "R8 other sector");

    // R7 erase blocked
    wel = 1'b0;
    erase3(24'h000200);
    read1(24'h000210, 8'h42, "R7 erase no latch");
    wel = 1'b1; plo = 32'h200; phi = 32'h3FF;
    erase3(24'h000210);
    read1(24'h000210, 8'h42, "R7 erase denied");
    plo = 32'hFFFF_FFFF; phi = 32'h0;

    // R9 bulk erase
    bulk_ok = 1'b0;
    one(8'hC7);
    read1(24'h000210, 8'h42, "R7 bulk denied");
    bulk_ok = 1'b1;
    one(8'hC7);
    read1(24'h000210, 8'hFF, "R9 bulk a");
    read1(24'h000380, 8'hFF, "R9 bulk b");

    // R1 unknown opcode
    fbeg(); xb(8'h5A, 1, 8'hFF, "R1 unknown"); xb(8'h9F, 1, 8'hFF, "R1 ignored");
    xb(8'h00, 1, 8'hFF, "R1 ignored2"); fend();

    // R10 abort
    fbeg(); xb(8'h03, 0, 0, ""); xb(8'h00, 0, 0, ""); fend();
    fbeg(); xb(8'h9F, 1, 8'h20, "R10 abort read"); fend();
    fbeg(); xb(8'h02, 0, 0, ""); xb(8'h00, 0, 0, ""); xb(8'h02, 0, 0, ""); fend();
    fbeg(); xb(8'h9F, 1, 8'h20, "R10 abort prog"); fend();

    // R4 four-byte addressing across frames
    one(8'hB7);
    fbeg(); xb(8'h02, 0, 0, ""); xb(8'h00, 0, 0, ""); xb(8'h00, 0, 0, ""); xb(8'h02, 0, 0, "");
    xb(8'h20, 0, 0, ""); xb(8'h77, 0, 0, ""); fend();
    fbeg(); xb(8'h03, 0, 0, ""); xb(8'h00, 0, 0, ""); xb(8'h00, 0, 0, ""); xb(8'h02, 1, 8'hFF, "R4 still addr");
    xb(8'h20, 1, 8'h77, "R4 four bytes"); xb(8'h00, 1, 8'hFF, "R4 next"); fend();

    // R11 reset leaves four-byte mode
    do_reset();
    prog3(24'h000020, 8'h12);
    read1(24'h000020, 8'h12, "R11 three-byte after reset");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule